// File: doc/BRIEF.md
# I/O Bus Adapter Control and Status Register

This block is the control and status register of an I/O bus adapter. It collects four error flags and a power-fail flag raised by single-cycle strobes from the adapter logic. It holds a disable-transfer control bit and two 3-bit interrupt level selections, one for high-priority bus requests and one for low-priority bus requests. Each level selection is decoded into a one-hot interrupt mask that an interrupt mapper uses to route bus requests to the processor's priority interrupt levels.

A single write port updates the register with mixed rules. Error flags are cleared only where a one is written. The power-fail flag is cleared by any write. The disable-transfer bit and the level fields take the written value. A write that carries the bus-init command starts a bus reset: the two level fields are forced to zero whatever data came with them, the init bit never stays set, and a one-cycle bus-init pulse is issued. A small state machine with two states, `ST_IDLE` and `ST_INIT_PULSE`, generates that pulse. A write with the init bit moves it from `ST_IDLE` to `ST_INIT_PULSE`. It returns to `ST_IDLE` on the next cycle unless another init write arrives, in which case it stays in `ST_INIT_PULSE`. The read port returns the register contents zero-extended to 32 bits.

Top module: `bus_adapter_csr`

## Requirements
- R1: After reset, the read value is 0, both interrupt masks are 0 and the bus-init pulse is low.
- R2: A write clears each error flag (timeout at bit 17, bad data at bit 16, parity at bit 15, nonexistent device at bit 14) whose data bit is 1. A flag whose data bit is 0 keeps its value.
- R3: An error strobe sets its flag on the clock edge where it is high. When a strobe and a clearing write for the same flag arrive in the same cycle, the flag ends up set.
- R4: The power-fail flag (bit 13) is set by its strobe and is cleared by every write regardless of the data. A strobe in the same cycle as a write leaves the flag set.
- R5: Every write loads the disable-transfer bit (bit 7) from data bit 7.
- R6: A write with data bit 6 (init) at 0 loads the high level field (bits 5:3) and the low level field (bits 2:0) from the same data bits.
- R7: A write with data bit 6 at 1 leaves both level fields at 0 and reads back with bit 6 at 0. It still loads the disable-transfer bit and still applies the flag rules.
- R8: Each level field value n from 1 to 7 drives exactly bit n of its 7-bit mask (bits 7:1). A value of 0 drives an all-zero mask.
- R9: A write with data bit 6 at 1 makes the bus-init output high for exactly the one cycle after that write edge, unless another init write follows directly.
- R10: Read bits 31:18, 12:8 and 6 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 18 | Write data |
| rd_data | output | 32 | Register contents, zero-extended |
| set_timeout | input | 1 | Timeout error strobe |
| set_bad_data | input | 1 | Bad memory data error strobe |
| set_parity | input | 1 | Parity error strobe |
| set_no_dev | input | 1 | Nonexistent device error strobe |
| set_power_fail | input | 1 | Power-fail strobe |
| hi_pi_mask | output | 7 | One-hot mask for the high level, bits 7:1 |
| lo_pi_mask | output | 7 | One-hot mask for the low level, bits 7:1 |
| bus_init_pulse | output | 1 | One-cycle bus-init pulse |

## Verification
The bench sweeps all 64 pairs of level fields with init clear and all init writes. A swapped or shifted field shows up as a wrong mask bit. A design that keeps the levels during init drives a nonzero mask after the bus reset. All 16 clear patterns are applied to fully set error flags, which catches a design that clears on zero or toggles. Strobes that collide with a clearing write expose wrong priority. A write of all zeros exposes a power-fail flag that is cleared only by a one. The bench also measures the pulse width and spots a missing pulse or one that lasts too long.

// File: rtl/csr_pkg.sv
package csr_pkg;
    localparam int DATA_W   = 18;
    localparam int ERR_N    = 4;
    localparam int ERR_LSB  = 14;
    localparam int PWR_BIT  = 13;
    localparam int DXF_BIT  = 7;
    localparam int INIT_BIT = 6;
    localparam int HI_LSB   = 3;
    localparam int LO_LSB   = 0;

    typedef enum logic {
        ST_IDLE       = 1'b0,
        ST_INIT_PULSE = 1'b1
    } init_state_e;
endpackage

// File: rtl/pi_level_decode.sv
module pi_level_decode #(
    parameter int LVL_W  = 3,
    parameter int MASK_W = (1 << LVL_W) - 1
) (
    input  logic [LVL_W-1:0]  level,
    output logic [MASK_W:1]   mask
);
    for (genvar n = 1; n <= MASK_W; n++) begin : g_bit
        assign mask[n] = (level == LVL_W'(n));
    end

    always_comb begin
        assert_onehot_R8: assert ($onehot0(mask));
    end
endmodule

// File: rtl/csr_flags.sv
module csr_flags #(
    parameter int ERR_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ERR_N-1:0] wr_clr,
    input  logic [ERR_N-1:0] err_set,
    input  logic             pwr_set,
    output logic [ERR_N-1:0] err_q,
    output logic             pwr_q
);
    logic [ERR_N-1:0] clr_mask;

    always_comb begin
        clr_mask = wr_en ? wr_clr : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
            pwr_q <= 1'b0;
        end else begin
            err_q <= (err_q & ~clr_mask) | err_set;
            pwr_q <= (pwr_q & ~wr_en) | pwr_set;
        end
    end

    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && err_set == '0) |=> ((err_q & $past(wr_clr)) == '0));
    assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && err_set == '0) |=> ((err_q & ~$past(wr_clr)) == ($past(err_q) & ~$past(wr_clr))));
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != '0) |=> ((err_q & $past(err_set)) == $past(err_set)));
    assert_pwr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pwr_set) |=> !pwr_q);
    assert_pwr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_set |=> pwr_q);
endmodule

// File: rtl/bus_adapter_csr.sv
module bus_adapter_csr
    import csr_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int RD_W   = 32,
    localparam int MASK_W = (1 << LVL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [RD_W-1:0]   rd_data,
    input  logic              set_timeout,
    input  logic              set_bad_data,
    input  logic              set_parity,
    input  logic              set_no_dev,
    input  logic              set_power_fail,
    output logic [MASK_W:1]   hi_pi_mask,
    output logic [MASK_W:1]   lo_pi_mask,
    output logic              bus_init_pulse
);
    init_state_e      state_q, state_d;
    logic [LVL_W-1:0] hi_lvl_q, lo_lvl_q;
    logic             dxf_q;
    logic [ERR_N-1:0] err_q;
    logic             pwr_q;
    logic             init_wr;

    assign init_wr = wr_en && wr_data[INIT_BIT];

    csr_flags #(.ERR_N(ERR_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_clr  (wr_data[ERR_LSB +: ERR_N]),
        .err_set ({set_timeout, set_bad_data, set_parity, set_no_dev}),
        .pwr_set (set_power_fail),
        .err_q   (err_q),
        .pwr_q   (pwr_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_lvl_q <= '0;
            lo_lvl_q <= '0;
            dxf_q    <= 1'b0;
        end else if (wr_en) begin
            dxf_q <= wr_data[DXF_BIT];
            if (wr_data[INIT_BIT]) begin
                hi_lvl_q <= '0;
                lo_lvl_q <= '0;
            end else begin
                hi_lvl_q <= wr_data[HI_LSB +: LVL_W];
                lo_lvl_q <= wr_data[LO_LSB +: LVL_W];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       state_d = init_wr ? ST_INIT_PULSE : ST_IDLE;
            ST_INIT_PULSE: state_d = init_wr ? ST_INIT_PULSE : ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_init_pulse = (state_q == ST_INIT_PULSE);
    end

    always_comb begin
        rd_data = '0;
        rd_data[ERR_LSB +: ERR_N] = err_q;
        rd_data[PWR_BIT]          = pwr_q;
        rd_data[DXF_BIT]          = dxf_q;
        rd_data[HI_LSB +: LVL_W]  = hi_lvl_q;
        rd_data[LO_LSB +: LVL_W]  = lo_lvl_q;
    end

    pi_level_decode #(.LVL_W(LVL_W), .MASK_W(MASK_W)) u_hi_dec (
        .level (hi_lvl_q),
        .mask  (hi_pi_mask)
    );
    pi_level_decode #(.LVL_W(LVL_W), .MASK_W(MASK_W)) u_lo_dec (
        .level (lo_lvl_q),
        .mask  (lo_pi_mask)
    );

    assert_init_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (hi_pi_mask == '0 && lo_pi_mask == '0));
    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init_pulse |-> $past(init_wr));
    assert_pulse_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> bus_init_pulse);
    assert_dxf_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[DXF_BIT] == $past(wr_data[DXF_BIT])));
endmodule

// File: tb/tb_bus_adapter_csr.sv
module tb_bus_adapter_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        s_to = 0, s_bd = 0, s_par = 0, s_nd = 0, s_pw = 0;
    logic [7:1]  hi_pi_mask, lo_pi_mask;
    logic        bus_init_pulse;
    int          errors = 0, checks = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    bus_adapter_csr dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .set_timeout(s_to), .set_bad_data(s_bd),
        .set_parity(s_par), .set_no_dev(s_nd), .set_power_fail(s_pw),
        .hi_pi_mask(hi_pi_mask), .lo_pi_mask(lo_pi_mask),
        .bus_init_pulse(bus_init_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, starting and ending at a falling edge
    task automatic cyc(input logic w, input logic [17:0] d, input logic [4:0] s);
        wr_en = w; wr_data = d;
        {s_to, s_bd, s_par, s_nd, s_pw} = s;
        @(negedge clk);
        wr_en = 0; wr_data = '0;
        {s_to, s_bd, s_par, s_nd, s_pw} = '0;
    endtask

    function automatic logic [7:0] onehot(input int lvl);
        return (lvl == 0) ? 8'd0 : (8'd1 << lvl);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 read", rd_data, 0);
        chk("R1 masks", {16'd0, hi_pi_mask, lo_pi_mask}, 0);
        chk("R1 pulse", {31'd0, bus_init_pulse}, 0);

        // R6/R8/R5/R10: every level pair, dxf toggled
        for (int v = 0; v < 64; v++) begin
            logic [17:0] d;
            d = 18'(v) | ((v % 2) ? 18'h80 : 18'h0);
            cyc(1, d, 0);
            chk("R6 R5 R10 readback", rd_data, {14'd0, 4'd0, 1'b0, 5'd0, d[7], 1'b0, d[5:0]});
            chk("R8 hi mask", {24'd0, hi_pi_mask, 1'b0}, {24'd0, onehot(v / 8)});
            chk("R8 lo mask", {24'd0, lo_pi_mask, 1'b0}, {24'd0, onehot(v % 8)});
            chk("R9 no pulse", {31'd0, bus_init_pulse}, 0);
        end

        // R7/R9: init writes clear levels, pulse one cycle
        for (int v = 0; v < 16; v++) begin
            logic [17:0] d;
            cyc(1, 18'o77, 0);
            d = 18'h40 | (18'(v) << 2) | ((v % 2) ? 18'h80 : 18'h0);
            cyc(1, d, 0);
            chk("R7 readback", rd_data, {24'd0, d[7], 7'd0});
            chk("R7 masks", {16'd0, hi_pi_mask, lo_pi_mask}, 0);
            chk("R9 pulse high", {31'd0, bus_init_pulse}, 1);
            @(negedge clk);
            chk("R9 pulse low", {31'd0, bus_init_pulse}, 0);
        end
        cyc(1, 18'h40, 0);
        cyc(1, 18'h40, 0);
        chk("R9 back-to-back", {31'd0, bus_init_pulse}, 1);
        @(negedge clk);
        chk("R9 back-to-back end", {31'd0, bus_init_pulse}, 0);

        // R2: every clear pattern on fully set flags
        for (int p = 0; p < 16; p++) begin
            cyc(0, 0, 5'b11110);
            chk("R3 set all", {28'd0, rd_data[17:14]}, 32'hF);
            cyc(1, 18'(p) << 14, 0);
            chk("R2 w1c", {28'd0, rd_data[17:14]}, {28'd0, ~4'(p)});
            cyc(1, 0, 0);
            chk("R2 zero keeps", {28'd0, rd_data[17:14]}, {28'd0, ~4'(p)});
            cyc(1, 18'o740000, 0);
        end

        // R3: strobe collides with clear
        cyc(1, 18'o740000, 5'b10100);
        chk("R3 strobe beats clear", {28'd0, rd_data[17:14]}, 32'hA);
        cyc(1, 18'o740000, 5'b01010);
        chk("R3 strobe beats clear 2", {28'd0, rd_data[17:14]}, 32'h5);
        cyc(1, 18'o740000, 0);

        // R4: power-fail
        cyc(0, 0, 5'b00001);
        chk("R4 set", {31'd0, rd_data[13]}, 1);
        cyc(0, 0, 0);
        chk("R4 hold", {31'd0, rd_data[13]}, 1);
        cyc(1, 0, 0);
        chk("R4 cleared by zero write", {31'd0, rd_data[13]}, 0);
        cyc(1, 0, 5'b00001);
        chk("R4 strobe beats write", {31'd0, rd_data[13]}, 1);

        // R10: all-ones write
        cyc(1, 18'h3FFFF, 5'b11111);
        chk("R10 unused zero", rd_data & 32'hFFFC1F40, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule